// File: doc/BRIEF.md
# Per-CPU Interrupt Presentation Controller

This block sits next to one processor and holds at most one interrupt for it. Sources deliver a source number and a priority. The block admits the delivery into its single pending slot or refuses it, then drives the processor's interrupt line. Priorities follow the rule that a smaller value is more favoured. A more favoured arrival displaces the held interrupt, and the displaced interrupt goes back to its source as a reject. A separate inter-processor-interrupt (IPI) priority register lets the processor's own IPI compete for the same slot under the same rule.

Software works the block through a small operation port with five operations. Accept takes the pending interrupt and raises the current priority to its level. Poll reads the state without changing it. Set-current-priority can cancel a presented interrupt or ask the sources to resend. Set-IPI-priority requests an IPI. End-of-interrupt restores a priority, reports the completed source and, when the slot is empty, asks for a resend. Every result toward the sources is a one-cycle pulse, registered after the edge that samples the request.

Top module: `intr_present_unit`

## Requirements
- R1: After reset the interrupt word (current priority in bits 31:24, pending source in bits 23:0) reads 0, the IPI priority reads 0xFF, irq_o is low and no pulse output is high.
- R2: Operation codes are 1 accept, 2 poll, 3 set current priority (op_data_i[7:0]), 4 set IPI priority (op_data_i[7:0]) and 5 end-of-interrupt (op_data_i[31:0]). An accept or poll gives rd_valid_o one cycle later, with rd_word_o holding the word as it was before the operation and rd_ipi_o holding the IPI priority. A poll changes no state and raises no pulse.
- R3: A delivery is refused when its priority is greater than or equal to the current priority, or when a pending interrupt has a priority less than or equal to the delivery's. nack_o then pulses one cycle later with nack_src_o equal to the delivered source.
- R4: An admitted delivery loads its source into bits 23:0 and asserts irq_o. If the slot held an interrupt from a source, rej_o pulses with that interrupt's number. A displaced IPI raises no reject.
- R5: Accept returns the prior word, drops irq_o, moves the pending priority into bits 31:24, clears bits 23:0 and resets the pending priority to 0xFF.
- R6: Writing a current priority below the old one cancels the pending interrupt when the new value is less than or equal to its priority. The cancel clears the slot, drops irq_o and rejects the interrupt if it came from a source.
- R7: Writing a current priority equal to or above the old one while the slot is empty pulses resend_o. If the IPI priority is below the new current priority, the IPI is loaded in the same step.
- R8: Writing the IPI priority below the current priority loads source IPI_SRC at that priority and asserts irq_o. This does not happen when a pending interrupt has a priority less than or equal to the IPI priority. A source-owned interrupt displaced this way is rejected.
- R9: End-of-interrupt copies bits 31:24 of the written word into the current priority and pulses eoi_o with eoi_src_o equal to bits 23:0. If the slot is empty it pulses resend_o and runs the IPI check of R7 against the new priority.
- R10: A delivery arriving in the same cycle as any operation is refused through nack_o and leaves the slot untouched.
- R11: rej_o, nack_o, resend_o and eoi_o are single-cycle pulses that return low when no new cause is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dlv_valid_i | input | 1 | Delivery present this cycle |
| dlv_src_i | input | SRC_W | Delivered source number |
| dlv_prio_i | input | PRIO_W | Delivered priority |
| op_valid_i | input | 1 | Register operation present |
| op_code_i | input | 3 | Operation code (R2) |
| op_data_i | input | PRIO_W+SRC_W | Operation write data |
| irq_o | output | 1 | Processor interrupt line |
| rd_valid_o | output | 1 | Read result valid |
| rd_word_o | output | PRIO_W+SRC_W | Interrupt word before the operation |
| rd_ipi_o | output | PRIO_W | IPI priority |
| rej_o | output | 1 | Reject pulse toward sources |
| rej_src_o | output | SRC_W | Rejected source number |
| nack_o | output | 1 | Refused-delivery pulse |
| nack_src_o | output | SRC_W | Refused source number |
| resend_o | output | 1 | Resend request pulse |
| eoi_o | output | 1 | End-of-interrupt pulse |
| eoi_src_o | output | SRC_W | Completed source number |

## Verification
The checks assume that delivered source numbers are never zero and never equal IPI_SRC, and that op_code_i carries only the codes listed in R2 while op_valid_i is high. The stimulus table uses only nonzero source numbers from 0x10 upward, so IPI_SRC (2) is never delivered. Every operation in the table uses one of codes 1 to 5. Under these assumptions the pending slot is empty exactly when the pending priority is 0xFF, and the interrupt line follows the slot.

// File: rtl/ipu_pkg.sv
package ipu_pkg;
  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_NONE     = 3'd0,
    OP_ACCEPT   = 3'd1,
    OP_POLL     = 3'd2,
    OP_SET_CPPR = 3'd3,
    OP_SET_IPI  = 3'd4,
    OP_EOI      = 3'd5
  } ipu_op_e;

  typedef struct packed {
    logic accept;
    logic poll;
    logic set_cur;
    logic set_ipi;
    logic eoi;
  } ipu_op_t;
endpackage

// File: rtl/ipu_op_decode.sv
module ipu_op_decode
  import ipu_pkg::*;
(
  input  logic            valid_i,
  input  logic [OP_W-1:0] code_i,
  output ipu_op_t         sel_o,
  output logic            any_o
);
  always_comb begin
    sel_o = '0;
    if (valid_i) begin
      unique case (ipu_op_e'(code_i))
        OP_ACCEPT:   sel_o.accept  = 1'b1;
        OP_POLL:     sel_o.poll    = 1'b1;
        OP_SET_CPPR: sel_o.set_cur = 1'b1;
        OP_SET_IPI:  sel_o.set_ipi = 1'b1;
        OP_EOI:      sel_o.eoi     = 1'b1;
        default:     sel_o = '0;
      endcase
    end
  end

  assign any_o = |sel_o;
endmodule

// File: rtl/ipu_admit.sv
// Slot admission test shared by deliveries and the IPI check.
module ipu_admit #(
  parameter int PRIO_W = 8
) (
  input  logic [PRIO_W-1:0] cand_prio_i,
  input  logic [PRIO_W-1:0] cur_prio_i,
  input  logic              busy_i,
  input  logic [PRIO_W-1:0] held_prio_i,
  output logic              take_o
);
  logic below_cur, beaten;

  assign below_cur = cand_prio_i < cur_prio_i;
  assign beaten    = busy_i && (held_prio_i <= cand_prio_i);
  assign take_o    = below_cur && !beaten;
endmodule

// File: rtl/intr_present_unit.sv
module intr_present_unit
  import ipu_pkg::*;
#(
  parameter int SRC_W   = 24,
  parameter int PRIO_W  = 8,
  parameter int IPI_SRC = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    dlv_valid_i,
  input  logic [SRC_W-1:0]        dlv_src_i,
  input  logic [PRIO_W-1:0]       dlv_prio_i,
  input  logic                    op_valid_i,
  input  logic [2:0]              op_code_i,
  input  logic [PRIO_W+SRC_W-1:0] op_data_i,
  output logic                    irq_o,
  output logic                    rd_valid_o,
  output logic [PRIO_W+SRC_W-1:0] rd_word_o,
  output logic [PRIO_W-1:0]       rd_ipi_o,
  output logic                    rej_o,
  output logic [SRC_W-1:0]        rej_src_o,
  output logic                    nack_o,
  output logic [SRC_W-1:0]        nack_src_o,
  output logic                    resend_o,
  output logic                    eoi_o,
  output logic [SRC_W-1:0]        eoi_src_o
);
  localparam int WORD_W = PRIO_W + SRC_W;
  localparam logic [PRIO_W-1:0] IDLE_PRIO = {PRIO_W{1'b1}};
  localparam logic [SRC_W-1:0]  IPI_NUM   = SRC_W'(IPI_SRC);

  // slot and priority state
  logic [SRC_W-1:0]  slot_src_q,  slot_src_d;
  logic [PRIO_W-1:0] slot_prio_q, slot_prio_d;
  logic [PRIO_W-1:0] cur_prio_q,  cur_prio_d;
  logic [PRIO_W-1:0] ipi_prio_q,  ipi_prio_d;
  logic              owned_q,     owned_d;
  logic              irq_q,       irq_d;

  // registered outputs
  logic              rdv_q, rdv_d;
  logic [WORD_W-1:0] rdw_q, rdw_d;
  logic [PRIO_W-1:0] rdi_q, rdi_d;
  logic              rej_q, rej_d;
  logic [SRC_W-1:0]  rejs_q, rejs_d;
  logic              nack_q, nack_d;
  logic [SRC_W-1:0]  nacks_q, nacks_d;
  logic              rsnd_q, rsnd_d;
  logic              eoi_q, eoi_d;
  logic [SRC_W-1:0]  eois_q, eois_d;

  ipu_op_t op;
  logic    op_any;

  ipu_op_decode u_dec (
    .valid_i (op_valid_i),
    .code_i  (op_code_i),
    .sel_o   (op),
    .any_o   (op_any)
  );

  logic              busy;
  logic [PRIO_W-1:0] wr_lo, wr_hi;
  logic [PRIO_W-1:0] ipi_cand, ipi_cur;
  logic              ipi_take, dlv_take;

  assign busy  = slot_src_q != '0;
  assign wr_lo = op_data_i[PRIO_W-1:0];
  assign wr_hi = op_data_i[WORD_W-1:SRC_W];

  // IPI check sees the new IPI priority on its own write, the new current
  // priority on current-priority and EOI writes.
  assign ipi_cand = op.set_ipi ? wr_lo : ipi_prio_q;
  assign ipi_cur  = op.set_cur ? wr_lo : (op.eoi ? wr_hi : cur_prio_q);

  ipu_admit #(.PRIO_W(PRIO_W)) u_ipi_adm (
    .cand_prio_i (ipi_cand),
    .cur_prio_i  (ipi_cur),
    .busy_i      (busy),
    .held_prio_i (slot_prio_q),
    .take_o      (ipi_take)
  );

  ipu_admit #(.PRIO_W(PRIO_W)) u_dlv_adm (
    .cand_prio_i (dlv_prio_i),
    .cur_prio_i  (cur_prio_q),
    .busy_i      (busy),
    .held_prio_i (slot_prio_q),
    .take_o      (dlv_take)
  );

  always_comb begin
    logic do_ipi;
    slot_src_d  = slot_src_q;
    slot_prio_d = slot_prio_q;
    cur_prio_d  = cur_prio_q;
    ipi_prio_d  = ipi_prio_q;
    owned_d     = owned_q;
    irq_d       = irq_q;
    rdv_d   = 1'b0;
    rdw_d   = rdw_q;
    rdi_d   = rdi_q;
    rej_d   = 1'b0;
    rejs_d  = rejs_q;
    nack_d  = 1'b0;
    nacks_d = nacks_q;
    rsnd_d  = 1'b0;
    eoi_d   = 1'b0;
    eois_d  = eois_q;
    do_ipi  = 1'b0;

    if (op.accept || op.poll) begin
      rdv_d = 1'b1;
      rdw_d = {cur_prio_q, slot_src_q};
      rdi_d = ipi_prio_q;
    end

    if (op.accept) begin
      cur_prio_d  = slot_prio_q;
      slot_src_d  = '0;
      slot_prio_d = IDLE_PRIO;
      owned_d     = 1'b0;
      irq_d       = 1'b0;
    end

    if (op.set_cur) begin
      cur_prio_d = wr_lo;
      if (wr_lo < cur_prio_q) begin
        if (busy && (wr_lo <= slot_prio_q)) begin
          slot_src_d  = '0;
          slot_prio_d = IDLE_PRIO;
          owned_d     = 1'b0;
          irq_d       = 1'b0;
          if (owned_q) begin
            rej_d  = 1'b1;
            rejs_d = slot_src_q;
          end
        end
      end else if (!busy) begin
        rsnd_d = 1'b1;
        do_ipi = 1'b1;
      end
    end

    if (op.set_ipi) begin
      ipi_prio_d = wr_lo;
      do_ipi     = 1'b1;
    end

    if (op.eoi) begin
      cur_prio_d = wr_hi;
      eoi_d      = 1'b1;
      eois_d     = op_data_i[SRC_W-1:0];
      if (!busy) begin
        rsnd_d = 1'b1;
        do_ipi = 1'b1;
      end
    end

    if (do_ipi && ipi_take) begin
      if (busy && owned_q) begin
        rej_d  = 1'b1;
        rejs_d = slot_src_q;
      end
      slot_src_d  = IPI_NUM;
      slot_prio_d = ipi_cand;
      owned_d     = 1'b0;
      irq_d       = 1'b1;
    end

    if (dlv_valid_i) begin
      if (op_any || !dlv_take) begin
        nack_d  = 1'b1;
        nacks_d = dlv_src_i;
      end else begin
        if (busy && owned_q) begin
          rej_d  = 1'b1;
          rejs_d = slot_src_q;
        end
        slot_src_d  = dlv_src_i;
        slot_prio_d = dlv_prio_i;
        owned_d     = 1'b1;
        irq_d       = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_src_q  <= '0;
      slot_prio_q <= IDLE_PRIO;
      cur_prio_q  <= '0;
      ipi_prio_q  <= IDLE_PRIO;
      owned_q     <= 1'b0;
      irq_q       <= 1'b0;
      rdv_q   <= 1'b0;
      rdw_q   <= '0;
      rdi_q   <= '0;
      rej_q   <= 1'b0;
      rejs_q  <= '0;
      nack_q  <= 1'b0;
      nacks_q <= '0;
      rsnd_q  <= 1'b0;
      eoi_q   <= 1'b0;
      eois_q  <= '0;
    end else begin
      slot_src_q  <= slot_src_d;
      slot_prio_q <= slot_prio_d;
      cur_prio_q  <= cur_prio_d;
      ipi_prio_q  <= ipi_prio_d;
      owned_q     <= owned_d;
      irq_q       <= irq_d;
      rdv_q   <= rdv_d;
      rdw_q   <= rdw_d;
      rdi_q   <= rdi_d;
      rej_q   <= rej_d;
      rejs_q  <= rejs_d;
      nack_q  <= nack_d;
      nacks_q <= nacks_d;
      rsnd_q  <= rsnd_d;
      eoi_q   <= eoi_d;
      eois_q  <= eois_d;
    end
  end

  assign irq_o      = irq_q;
  assign rd_valid_o = rdv_q;
  assign rd_word_o  = rdw_q;
  assign rd_ipi_o   = rdi_q;
  assign rej_o      = rej_q;
  assign rej_src_o  = rejs_q;
  assign nack_o     = nack_q;
  assign nack_src_o = nacks_q;
  assign resend_o   = rsnd_q;
  assign eoi_o      = eoi_q;
  assign eoi_src_o  = eois_q;
endmodule

// File: rtl/ipu_chk.sv
module ipu_chk
  import ipu_pkg::*;
#(
  parameter int SRC_W  = 24,
  parameter int PRIO_W = 8
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    op_valid_i,
  input logic [2:0]              op_code_i,
  input logic [PRIO_W+SRC_W-1:0] op_data_i,
  input logic                    dlv_valid_i,
  input logic                    irq_o,
  input logic                    rd_valid_o,
  input logic                    nack_o,
  input logic                    eoi_o,
  input logic [SRC_W-1:0]        eoi_src_o,
  input logic [SRC_W-1:0]        slot_src_q,
  input logic [PRIO_W-1:0]       slot_prio_q
);
  logic is_acc, is_poll, is_eoi;
  assign is_acc  = op_valid_i && (op_code_i == OP_ACCEPT);
  assign is_poll = op_valid_i && (op_code_i == OP_POLL);
  assign is_eoi  = op_valid_i && (op_code_i == OP_EOI);

  // R4
  irq_follows_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (slot_src_q != '0));

  // R1
  idle_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_src_q == '0) == (slot_prio_q == {PRIO_W{1'b1}}));

  // R5
  accept_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_acc |=> (!irq_o && rd_valid_o && slot_src_q == '0));

  // R2
  poll_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_poll && !dlv_valid_i) |=> (slot_src_q == $past(slot_src_q) && slot_prio_q == $past(slot_prio_q)));

  // R9
  eoi_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_eoi |=> (eoi_o && eoi_src_o == $past(op_data_i[SRC_W-1:0])));

  // R10
  clash_nack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dlv_valid_i && op_valid_i && op_code_i != OP_NONE) |=> nack_o);

  // R11
  eoi_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_o && !is_eoi) |=> !eoi_o);
endmodule

bind intr_present_unit ipu_chk #(.SRC_W(SRC_W), .PRIO_W(PRIO_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .op_valid_i  (op_valid_i),
  .op_code_i   (op_code_i),
  .op_data_i   (op_data_i),
  .dlv_valid_i (dlv_valid_i),
  .irq_o       (irq_o),
  .rd_valid_o  (rd_valid_o),
  .nack_o      (nack_o),
  .eoi_o       (eoi_o),
  .eoi_src_o   (eoi_src_o),
  .slot_src_q  (slot_src_q),
  .slot_prio_q (slot_prio_q)
);

// File: tb/intr_present_unit_tb_top.sv
module intr_present_unit_tb_top;
  localparam int SRC_W = 24;
  localparam int PRIO_W = 8;
  localparam int W = 32;
  localparam int NV = 25;

  // {act, data, pulses{rej,nack,resend,eoi}, src, irq, word, ipi}
  localparam logic [104:0] VEC [NV] = '{
    {4'd3, 32'h000000FF, 4'b0010, 24'h0,  1'b0, 32'hFF000000, 8'hFF},
    {4'd0, 32'h05000010, 4'b0000, 24'h0,  1'b1, 32'hFF000010, 8'hFF},
    {4'd0, 32'h07000011, 4'b0100, 24'h11, 1'b1, 32'hFF000010, 8'hFF},
    {4'd0, 32'h05000012, 4'b0100, 24'h12, 1'b1, 32'hFF000010, 8'hFF},
    {4'd0, 32'h03000013, 4'b1000, 24'h10, 1'b1, 32'hFF000013, 8'hFF},
    {4'd1, 32'h00000000, 4'b0000, 24'h0,  1'b0, 32'h03000000, 8'hFF},
    {4'd0, 32'h03000014, 4'b0100, 24'h14, 1'b0, 32'h03000000, 8'hFF},
    {4'd0, 32'h01000015, 4'b0000, 24'h0,  1'b1, 32'h03000015, 8'hFF},
    {4'd3, 32'h00000002, 4'b0000, 24'h0,  1'b1, 32'h02000015, 8'hFF},
    {4'd3, 32'h00000001, 4'b1000, 24'h15, 1'b0, 32'h01000000, 8'hFF},
    {4'd4, 32'h00000000, 4'b0000, 24'h0,  1'b1, 32'h01000002, 8'h00},
    {4'd0, 32'h00000016, 4'b0100, 24'h16, 1'b1, 32'h01000002, 8'h00},
    {4'd1, 32'h00000000, 4'b0000, 24'h0,  1'b0, 32'h00000000, 8'h00},
    {4'd5, 32'h05000015, 4'b0011, 24'h15, 1'b1, 32'h05000002, 8'h00},
    {4'd4, 32'h000000FF, 4'b0000, 24'h0,  1'b1, 32'h05000002, 8'hFF},
    {4'd1, 32'h00000000, 4'b0000, 24'h0,  1'b0, 32'h00000000, 8'hFF},
    {4'd5, 32'hFF000002, 4'b0011, 24'h02, 1'b0, 32'hFF000000, 8'hFF},
    {4'd0, 32'h09000020, 4'b0000, 24'h0,  1'b1, 32'hFF000020, 8'hFF},
    {4'd4, 32'h00000004, 4'b1000, 24'h20, 1'b1, 32'hFF000002, 8'h04},
    {4'd4, 32'h00000006, 4'b0000, 24'h0,  1'b1, 32'hFF000002, 8'h06},
    {4'd0, 32'h05000021, 4'b0100, 24'h21, 1'b1, 32'hFF000002, 8'h06},
    {4'd0, 32'h03000022, 4'b0000, 24'h0,  1'b1, 32'hFF000022, 8'h06},
    {4'd3, 32'h000000FF, 4'b0000, 24'h0,  1'b1, 32'hFF000022, 8'h06},
    {4'd1, 32'h00000000, 4'b0000, 24'h0,  1'b0, 32'h03000000, 8'h06},
    {4'd5, 32'hFF000022, 4'b0011, 24'h22, 1'b1, 32'hFF000002, 8'h06}
  };

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic dlv_valid_i = 1'b0;
  logic [SRC_W-1:0] dlv_src_i = '0;
  logic [PRIO_W-1:0] dlv_prio_i = '0;
  logic op_valid_i = 1'b0;
  logic [2:0] op_code_i = '0;
  logic [W-1:0] op_data_i = '0;
  logic irq_o, rd_valid_o, rej_o, nack_o, resend_o, eoi_o;
  logic [W-1:0] rd_word_o;
  logic [PRIO_W-1:0] rd_ipi_o;
  logic [SRC_W-1:0] rej_src_o, nack_src_o, eoi_src_o;

  int checks = 0;
  int errs = 0;

  always #2.5 clk_i = ~clk_i;

  intr_present_unit dut_i (
    .clk_i, .rst_ni, .dlv_valid_i, .dlv_src_i, .dlv_prio_i,
    .op_valid_i, .op_code_i, .op_data_i, .irq_o, .rd_valid_o,
    .rd_word_o, .rd_ipi_o, .rej_o, .rej_src_o, .nack_o, .nack_src_o,
    .resend_o, .eoi_o, .eoi_src_o
  );

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string req_of(input logic [3:0] a, input logic [3:0] p);
    case (a)
      4'd0: return p[2] ? "R3" : "R4";
      4'd1: return "R5";
      4'd3: return p[1] ? "R7" : "R6";
      4'd4: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic apply(input logic [3:0] a, input logic [W-1:0] d);
    @(negedge clk_i);
    if (a == 4'd0) begin
      dlv_valid_i = 1'b1;
      dlv_prio_i = d[31:24];
      dlv_src_i = d[23:0];
    end else begin
      op_valid_i = 1'b1;
      op_code_i = a[2:0];
      op_data_i = d;
    end
    @(negedge clk_i);
    dlv_valid_i = 1'b0;
    op_valid_i = 1'b0;
    op_code_i = '0;
  endtask

  task automatic poll_chk(input logic [W-1:0] ew, input logic [7:0] ei, input string req);
    apply(4'd2, '0);
    chk(rd_valid_o == 1'b1, "R2", W'(rd_valid_o), 1);
    chk(rd_word_o == ew, req, rd_word_o, ew);
    chk(rd_ipi_o == ei, req, W'(rd_ipi_o), W'(ei));
    // R11: pulses of the previous step must be gone
    chk({rej_o, nack_o, resend_o, eoi_o} == 4'b0, "R11", W'({rej_o, nack_o, resend_o, eoi_o}), 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk_i);
    errs++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin : main
    logic [W-1:0] prev_word;
    repeat (3) @(negedge clk_i);
    // R1
    chk(irq_o == 1'b0, "R1", W'(irq_o), 0);
    chk({rej_o, nack_o, resend_o, eoi_o} == 4'b0, "R1", W'({rej_o, nack_o, resend_o, eoi_o}), 0);
    rst_ni = 1'b1;
    poll_chk(32'h0, 8'hFF, "R1");
    prev_word = 32'h0;

    for (int i = 0; i < NV; i++) begin
      logic [3:0]  a;
      logic [W-1:0] d, ew;
      logic [3:0]  p;
      logic [23:0] es;
      logic        ei;
      logic [7:0]  eipi;
      string       rq;
      {a, d, p, es, ei, ew, eipi} = VEC[i];
      rq = req_of(a, p);
      apply(a, d);
      chk({rej_o, nack_o, resend_o, eoi_o} == p, rq, W'({rej_o, nack_o, resend_o, eoi_o}), W'(p));
      if (p[3]) chk(rej_src_o == es, rq, W'(rej_src_o), W'(es));
      else if (p[2]) chk(nack_src_o == es, rq, W'(nack_src_o), W'(es));
      else if (p[0]) chk(eoi_src_o == es, "R9", W'(eoi_src_o), W'(es));
      if (a == 4'd1) chk(rd_valid_o && rd_word_o == prev_word, "R5", rd_word_o, prev_word);
      chk(irq_o == ei, rq, W'(irq_o), W'(ei));
      poll_chk(ew, eipi, rq);
      prev_word = ew;
    end

    // R10: delivery alongside a poll is refused and leaves the slot alone
    @(negedge clk_i);
    op_valid_i = 1'b1;
    op_code_i = 3'd2;
    dlv_valid_i = 1'b1;
    dlv_prio_i = 8'h01;
    dlv_src_i = 24'h30;
    @(negedge clk_i);
    op_valid_i = 1'b0;
    op_code_i = '0;
    dlv_valid_i = 1'b0;
    chk(nack_o && nack_src_o == 24'h30, "R10", W'(nack_src_o), 32'h30);
    chk(rej_o == 1'b0, "R10", W'(rej_o), 0);
    chk(rd_word_o == 32'hFF000002, "R10", rd_word_o, 32'hFF000002);
    poll_chk(32'hFF000002, 8'h06, "R10");

    // R1: reset mid-run clears everything
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk(irq_o == 1'b0, "R1", W'(irq_o), 0);
    rst_ni = 1'b1;
    poll_chk(32'h0, 8'hFF, "R1");

    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule